// File: doc/BRIEF.md
# Pipelined Channel Sorter with Duplicate Merging

This block takes N parallel event lanes in every clock cycle and hands them back, a fixed number of cycles later, reordered by destination channel. Each lane record carries a valid bit, a sequence number, two accounting flags (replaced, replaced-by-non-data), a sub-address and a payload of channel and data. The lanes pass through a pipelined Batcher odd-even merge network. Each compare-exchange node holds one register stage per comparator column. A fresh set of lanes can enter in every cycle.

Each node compares two lanes, ordering first on the valid bit (valid lanes first) and then on the channel (ascending). When both lanes are valid and target the same channel, the node does not keep both. It keeps the newer event, judged by a wrap-around comparison of sequence numbers, and sets the replaced flag on the kept lane. It also sets the non-data flag when the discarded event had a nonzero sub-address. Any flags that either lane already carried are ORed into the kept lane. The discarded lane leaves the node invalid. The block suits an event scheduler that must collapse several writes to one channel into a single surviving write before dispatch.

Top module: `lsn_sort_net`

## Requirements
- R1: Lane records presented in one cycle reach the outputs exactly LAT = L·(L+1)/2 cycles later, where L = log2(N). Lane counts of 2, 4 and 8 give latencies of 1, 3 and 6.
- R2: While reset (rst_n low) is sampled at a clock edge, every output valid bit is 0 after that edge.
- R3: When the valid inputs carry distinct channels, every valid input reappears with all of its fields unchanged. This covers the sequence number, both flags, sub-address, channel and data. The valid outputs sit in lanes 0 upward in ascending channel order.
- R4: When the valid inputs carry distinct channels, the number of valid outputs equals the number of valid inputs, and all invalid outputs occupy the highest lanes.
- R5: When several valid inputs share a channel, exactly one valid output carries that channel. Its record (sequence number, sub-address, data) is the record of the newest of those inputs. Sequence x is newer than y when (x − y) mod 2^SW lies in 1 … 2^(SW−1)−1, so the comparison wraps around.
- R6: The surviving output of a merged channel has its replaced flag set to 1. When no valid input has a channel collision and no input replaced flag is set, no valid output has the replaced flag set.
- R7: The non-data flag of a surviving output is 1 when any discarded event of its channel had a nonzero sub-address, or when any merged input already carried the flag. Otherwise it is 0.
- R8: Every valid output carries the sequence number, sub-address, channel and data of some valid input from LAT cycles earlier, and there are never more valid outputs than there were valid inputs.
- R9: A new set of lanes is accepted in every cycle, and consecutive sets do not interfere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, clears stage valid bits |
| in_vld | input | N | Valid bit per input lane |
| in_seq | input | N*SW | Sequence number per lane, lane i at [i*SW +: SW] |
| in_rpl | input | N | Incoming replaced flag per lane |
| in_ndr | input | N | Incoming non-data-replaced flag per lane |
| in_sub | input | N*AW | Sub-address per lane; nonzero marks a non-data event |
| in_chan | input | N*CW | Channel per lane, lane i at [i*CW +: CW] |
| in_data | input | N*DW | Data per lane, lane i at [i*DW +: DW] |
| out_vld | output | N | Valid bit per output lane |
| out_seq | output | N*SW | Sequence number per output lane |
| out_rpl | output | N | Replaced flag per output lane |
| out_ndr | output | N | Non-data-replaced flag per output lane |
| out_sub | output | N*AW | Sub-address per output lane |
| out_chan | output | N*CW | Channel per output lane |
| out_data | output | N*DW | Data per output lane |

## Verification
The bench builds the block with eight lanes, a 4-bit sequence number, a 3-bit channel and a 2-bit sub-address. Eight lanes need all six comparator columns, so merges chain across columns, and three- to eight-way collisions on a single channel are possible. The wider sequence number keeps every pair in such a group inside the unambiguous window. It still lets the bench cross the wrap point from 15 to 0.

// File: rtl/lsn_pkg.sv
package lsn_pkg;

  // Number of comparator columns for a network of 2**l lanes.
  function automatic int num_cols(input int l);
    return (l * (l + 1)) / 2;
  endfunction

  // Merge block size p of column c.
  function automatic int col_p(input int l, input int c);
    int base;
    base = 0;
    for (int s = 0; s < l; s++) begin
      if (c < base + s + 1) return 1 << s;
      base = base + s + 1;
    end
    return 1;
  endfunction

  // Comparator distance k of column c.
  function automatic int col_k(input int l, input int c);
    int base;
    base = 0;
    for (int s = 0; s < l; s++) begin
      if (c < base + s + 1) return 1 << (s - (c - base));
      base = base + s + 1;
    end
    return 1;
  endfunction

  // Lane role in a column: 0 pass, 1 low side of a node, 2 high side.
  function automatic int low_side(input int n, input int p, input int k, input int x);
    int off;
    off = k % p;
    if (x < off) return 0;
    if (((x - off) % (2 * k)) >= k) return 0;
    if (x + k > n - 1) return 0;
    if ((x / (2 * p)) != ((x + k) / (2 * p))) return 0;
    return 1;
  endfunction

  function automatic int lane_role(input int n, input int p, input int k, input int x);
    if (low_side(n, p, k, x) == 1) return 1;
    if (x >= k && low_side(n, p, k, x - k) == 1) return 2;
    return 0;
  endfunction

  // Wrap-around recency: a is newer than b.
  function automatic logic seq_newer(input logic [31:0] a, input logic [31:0] b,
                                     input int w);
    logic [31:0] mask;
    logic [31:0] d;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    d    = (a - b) & mask;
    return (d != 32'd0) && (d < (32'd1 << (w - 1)));
  endfunction

endpackage

// File: rtl/lsn_node.sv
module lsn_node #(
  parameter int SW = 2,
  parameter int AW = 2,
  parameter int CW = 3,
  parameter int DW = 32,
  localparam int C0 = DW,
  localparam int A0 = DW + CW,
  localparam int S0 = DW + CW + AW,
  localparam int ND = S0 + SW,
  localparam int RP = ND + 1,
  localparam int VB = RP + 1,
  localparam int LW = VB + 1
) (
  input  logic [LW-1:0] lo_i,
  input  logic [LW-1:0] hi_i,
  output logic [LW-1:0] lo_o,
  output logic [LW-1:0] hi_o
);

  logic          same_chan;
  logic          hi_newer;
  logic          swap;
  logic [CW:0]   key_lo, key_hi;
  logic [LW-1:0] keep, drop;
  logic [31:0]   seq_lo32, seq_hi32;

  assign key_lo    = {~lo_i[VB], lo_i[C0 +: CW]};
  assign key_hi    = {~hi_i[VB], hi_i[C0 +: CW]};
  assign same_chan = lo_i[VB] && hi_i[VB] && (lo_i[C0 +: CW] == hi_i[C0 +: CW]);
  assign swap      = key_lo > key_hi;
  assign seq_lo32  = 32'(lo_i[S0 +: SW]);
  assign seq_hi32  = 32'(hi_i[S0 +: SW]);
  assign hi_newer  = lsn_pkg::seq_newer(seq_hi32, seq_lo32, SW);
  assign keep      = hi_newer ? hi_i : lo_i;
  assign drop      = hi_newer ? lo_i : hi_i;

  always_comb begin
    if (same_chan) begin
      lo_o     = keep;
      lo_o[RP] = 1'b1;
      lo_o[ND] = keep[ND] | drop[ND] | (drop[A0 +: AW] != '0);
      hi_o     = drop;
      hi_o[VB] = 1'b0;
    end else if (swap) begin
      lo_o = hi_i;
      hi_o = lo_i;
    end else begin
      lo_o = lo_i;
      hi_o = hi_i;
    end
  end

endmodule

// File: rtl/lsn_column.sv
module lsn_column #(
  parameter int N   = 8,
  parameter int COL = 0,
  parameter int SW  = 2,
  parameter int AW  = 2,
  parameter int CW  = 3,
  parameter int DW  = 32,
  localparam int L  = $clog2(N),
  localparam int LW = DW + CW + AW + SW + 3,
  localparam int VB = LW - 1,
  localparam int P  = lsn_pkg::col_p(L, COL),
  localparam int K  = lsn_pkg::col_k(L, COL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*LW-1:0] d_i,
  output logic [N*LW-1:0] q_o
);

  logic [LW-1:0] nxt [N];

  for (genvar x = 0; x < N; x++) begin : g_lane
    localparam int ROLE = lsn_pkg::lane_role(N, P, K, x);
    if (ROLE == 1) begin : g_node
      lsn_node #(.SW(SW), .AW(AW), .CW(CW), .DW(DW)) u_node (
        .lo_i (d_i[x*LW +: LW]),
        .hi_i (d_i[(x+K)*LW +: LW]),
        .lo_o (nxt[x]),
        .hi_o (nxt[x+K])
      );
    end else if (ROLE == 0) begin : g_pass
      assign nxt[x] = d_i[x*LW +: LW];
    end
  end

  for (genvar x = 0; x < N; x++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) q_o[x*LW + VB] <= 1'b0;
      else        q_o[x*LW +: LW] <= nxt[x];
    end
  end

endmodule

// File: rtl/lsn_sort_net.sv
module lsn_sort_net #(
  parameter int N  = 8,
  parameter int SW = 2,
  parameter int AW = 2,
  parameter int CW = 3,
  parameter int DW = 32,
  localparam int L   = $clog2(N),
  localparam int LAT = lsn_pkg::num_cols(L),
  localparam int LW  = DW + CW + AW + SW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]    in_vld,
  input  logic [N*SW-1:0] in_seq,
  input  logic [N-1:0]    in_rpl,
  input  logic [N-1:0]    in_ndr,
  input  logic [N*AW-1:0] in_sub,
  input  logic [N*CW-1:0] in_chan,
  input  logic [N*DW-1:0] in_data,
  output logic [N-1:0]    out_vld,
  output logic [N*SW-1:0] out_seq,
  output logic [N-1:0]    out_rpl,
  output logic [N-1:0]    out_ndr,
  output logic [N*AW-1:0] out_sub,
  output logic [N*CW-1:0] out_chan,
  output logic [N*DW-1:0] out_data
);

  logic [N*LW-1:0] stg [LAT+1];

  for (genvar x = 0; x < N; x++) begin : g_pack
    assign stg[0][x*LW +: LW] = {in_vld[x], in_rpl[x], in_ndr[x], in_seq[x*SW +: SW],
                                 in_sub[x*AW +: AW], in_chan[x*CW +: CW],
                                 in_data[x*DW +: DW]};
    assign {out_vld[x], out_rpl[x], out_ndr[x], out_seq[x*SW +: SW],
            out_sub[x*AW +: AW], out_chan[x*CW +: CW],
            out_data[x*DW +: DW]} = stg[LAT][x*LW +: LW];
  end

  for (genvar c = 0; c < LAT; c++) begin : g_col
    lsn_column #(.N(N), .COL(c), .SW(SW), .AW(AW), .CW(CW), .DW(DW)) u_col (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (stg[c]),
      .q_o   (stg[c+1])
    );
  end

endmodule

// File: rtl/lsn_sort_net_chk.sv
module lsn_sort_net_chk #(
  parameter int N  = 8,
  parameter int CW = 3,
  localparam int L    = $clog2(N),
  localparam int LAT  = lsn_pkg::num_cols(L),
  localparam int CNTW = $clog2(N + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    in_vld,
  input logic [N-1:0]    in_rpl,
  input logic [N*CW-1:0] in_chan,
  input logic [N-1:0]    out_vld,
  input logic [N-1:0]    out_rpl
);

  logic            col_now;
  logic [LAT-1:0]  col_h;
  logic [LAT-1:0]  rpl_h;
  logic [CNTW-1:0] cnt_h [LAT];

  always_comb begin
    col_now = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < i; j++)
        if (in_vld[i] && in_vld[j] && in_chan[i*CW +: CW] == in_chan[j*CW +: CW])
          col_now = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_h <= '0;
      rpl_h <= '0;
      for (int i = 0; i < LAT; i++) cnt_h[i] <= '0;
    end else begin
      col_h[0] <= col_now;
      rpl_h[0] <= |(in_rpl & in_vld);
      cnt_h[0] <= CNTW'($countones(in_vld));
      for (int i = 1; i < LAT; i++) begin
        col_h[i] <= col_h[i-1];
        rpl_h[i] <= rpl_h[i-1];
        cnt_h[i] <= cnt_h[i-1];
      end
    end
  end

  p_reset_clears_r2: assert property (@(posedge clk)
    !rst_n |=> (out_vld == '0));

  p_no_invent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_vld) <= int'(cnt_h[LAT-1]));

  p_unique_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !col_h[LAT-1] |-> ($countones(out_vld) == int'(cnt_h[LAT-1])));

  p_valid_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !col_h[LAT-1] |-> ((out_vld & (out_vld + 1'b1)) == '0));

  p_flag_needs_collision_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(out_rpl & out_vld)) && !rpl_h[LAT-1]) |-> col_h[LAT-1]);

endmodule

bind lsn_sort_net lsn_sort_net_chk #(.N(N), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .in_rpl  (in_rpl),
  .in_chan (in_chan),
  .out_vld (out_vld),
  .out_rpl (out_rpl)
);

// File: tb/sim_lsn_sort_net.sv
`timescale 1ns/1ps
module sim_lsn_sort_net;
  localparam int N = 8, SW = 4, AW = 2, CW = 3, DW = 32, LAT = 6, NV = 8;

  // stimulus vector: {valid mask, channels (lane i at 3i), seqs (4i), sub-addresses (2i)}
  localparam logic [79:0] VEC [NV] = '{
    {8'hFF, 24'o01234567, 32'h00000000, 16'h0000},
    {8'hFF, 24'o35172064, 32'h76543210, 16'h1B6C},
    {8'h5A, 24'o12345670, 32'h01234567, 16'h0000},
    {8'h00, 24'o00000000, 32'h00000000, 16'h0000},
    {8'hFF, 24'o33221100, 32'h12121212, 16'h0004},
    {8'hFF, 24'o55555555, 32'h76543210, 16'h0000},
    {8'h03, 24'o00000044, 32'h0000000F, 16'h0002},
    {8'hF0, 24'o66116100, 32'h89430000, 16'hC000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] in_vld = '0, in_rpl = '0, in_ndr = '0;
  logic [N*SW-1:0] in_seq = '0;
  logic [N*AW-1:0] in_sub = '0;
  logic [N*CW-1:0] in_chan = '0;
  logic [N*DW-1:0] in_data = '0;
  logic [N-1:0] out_vld, out_rpl, out_ndr;
  logic [N*SW-1:0] out_seq;
  logic [N*AW-1:0] out_sub;
  logic [N*CW-1:0] out_chan;
  logic [N*DW-1:0] out_data;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  lsn_sort_net #(.N(N), .SW(SW), .AW(AW), .CW(CW), .DW(DW)) u0 (.*);

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dat(input int e, input int i);
    return {8'(e), 8'(i), 16'hA5C3};
  endfunction

  function automatic logic newer(input int x, input int y);
    int d;
    d = (x + 16 - y) % 16;
    return d >= 1 && d <= 7;
  endfunction

  task automatic drive(input int e);
    logic [79:0] v;
    v = VEC[e];
    in_vld = v[79:72]; in_chan = v[71:48]; in_seq = v[47:16]; in_sub = v[15:0];
    in_rpl = '0; in_ndr = '0;
    for (int i = 0; i < N; i++) in_data[i*DW +: DW] = dat(e, i);
  endtask

  task automatic idle();
    in_vld = '0; in_rpl = '0; in_ndr = '0;
  endtask

  task automatic check_vec(input int e);
    logic [79:0] v;
    int win [8]; int size [8]; logic nd [8];
    int groups, pos, found;
    logic coll;
    v = VEC[e]; coll = 1'b0; groups = 0; pos = 0;
    for (int c = 0; c < 8; c++) begin
      size[c] = 0; win[c] = -1; nd[c] = 1'b0;
      for (int i = 0; i < N; i++)
        if (v[72+i] && int'(v[48+3*i +: 3]) == c) size[c]++;
      for (int i = 0; i < N; i++) begin
        logic best;
        if (!(v[72+i] && int'(v[48+3*i +: 3]) == c)) continue;
        best = 1'b1;
        for (int j = 0; j < N; j++)
          if (j != i && v[72+j] && int'(v[48+3*j +: 3]) == c &&
              !newer(int'(v[16+4*i +: 4]), int'(v[16+4*j +: 4]))) best = 1'b0;
        if (best) win[c] = i;
      end
      for (int i = 0; i < N; i++)
        if (v[72+i] && int'(v[48+3*i +: 3]) == c && i != win[c] && v[2*i +: 2] != 2'd0)
          nd[c] = 1'b1;
      if (size[c] > 0) groups++;
      if (size[c] > 1) coll = 1'b1;
    end
    if (!coll) begin
      // R3: ascending channel order, records unchanged; R4: invalid lanes last
      for (int c = 0; c < 8; c++) begin
        if (size[c] == 0) continue;
        chk(out_vld[pos] && out_chan[pos*CW +: CW] == 3'(c) &&
            out_seq[pos*SW +: SW] == v[16+4*win[c] +: 4] &&
            out_sub[pos*AW +: AW] == v[2*win[c] +: 2] &&
            out_data[pos*DW +: DW] == dat(e, win[c]) && !out_rpl[pos] && !out_ndr[pos],
            "R3", 64'(out_data[pos*DW +: DW]), 64'(dat(e, win[c])));
        pos++;
      end
      for (int i = pos; i < N; i++) chk(!out_vld[i], "R4", 64'(out_vld), 64'(i));
    end else begin
      chk($countones(out_vld) == groups, "R5", 64'($countones(out_vld)), 64'(groups));
      for (int c = 0; c < 8; c++) begin
        if (size[c] == 0) continue;
        found = -1;
        for (int i = 0; i < N; i++)
          if (out_vld[i] && out_chan[i*CW +: CW] == 3'(c)) found = i;
        // R5/R8: newest record of the channel survives
        chk(found >= 0 && out_seq[found*SW +: SW] == v[16+4*win[c] +: 4] &&
            out_data[found*DW +: DW] == dat(e, win[c]) &&
            out_sub[found*AW +: AW] == v[2*win[c] +: 2], "R5",
            64'(found), 64'(win[c]));
        if (found >= 0) begin
          chk(out_rpl[found] == (size[c] > 1), "R6", 64'(out_rpl[found]), 64'(size[c] > 1));
          chk(out_ndr[found] == nd[c], "R7", 64'(out_ndr[found]), 64'(nd[c]));
        end
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R2: outputs invalid during reset even with valid inputs
    drive(0);
    repeat (3) @(negedge clk);
    chk(out_vld == '0, "R2", 64'(out_vld), 64'd0);
    idle();
    rst_n = 1'b1;
    repeat (LAT + 1) @(negedge clk);

    // R9: back-to-back stream of all vectors, R8 checked per vector
    for (int t = 0; t < NV + LAT; t++) begin
      if (t >= LAT) check_vec(t - LAT);
      if (t < NV) drive(t); else idle();
      @(negedge clk);
    end

    // R1: exact latency
    idle();
    repeat (LAT) @(negedge clk);
    drive(0);
    @(negedge clk);
    idle();
    for (int d = 1; d <= LAT; d++) begin
      if (d < LAT) chk(out_vld == '0, "R1", 64'(out_vld), 64'd0);
      else         chk(out_vld == 8'hFF, "R1", 64'(out_vld), 64'hFF);
      @(negedge clk);
    end

    // R7/R3: incoming flags on unique channels pass through unchanged
    idle();
    in_vld[2] = 1'b1; in_chan[2*CW +: CW] = 3'd3; in_rpl[2] = 1'b1; in_ndr[2] = 1'b1;
    in_vld[5] = 1'b1; in_chan[5*CW +: CW] = 3'd1;
    @(negedge clk);
    idle();
    repeat (LAT - 1) @(negedge clk);
    chk(out_vld == 8'h03 && out_chan[2:0] == 3'd1 && !out_rpl[0] && !out_ndr[0],
        "R3", 64'(out_chan[2:0]), 64'd1);
    chk(out_chan[5:3] == 3'd3 && out_rpl[1] && out_ndr[1], "R7",
        64'({out_rpl[1], out_ndr[1]}), 64'd3);

    // R2: reset in mid-stream empties the outputs
    drive(1);
    repeat (LAT + 1) @(negedge clk);
    chk(out_vld == 8'hFF, "R9", 64'(out_vld), 64'hFF);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_vld == '0, "R2", 64'(out_vld), 64'd0);
    idle();
    rst_n = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule